// File: doc/BRIEF.md
# Integer Multiply-Accumulate and Divide Unit

This unit performs 32-bit integer multiplication, multiply-accumulate and division for a processor pipeline. It owns a pair of result registers, HI and LO, which together form a 64-bit accumulator. Multiplies complete in one cycle. Divides run on an iterative restoring divider, and the unit stays busy while the divider works.

The issuing stage raises `start` with an operation code, two operands and an optional writeback request. The unit signals completion with a single-cycle `done`. When writeback was requested for a multiply-family operation, `rd_valid` accompanies `done`, and the LO value is the result for the destination register. A zero divisor leaves HI and LO untouched and raises a one-cycle exception flag.

Top module: `muldiv_acc`

## Requirements
- R1: Operation code 000 multiplies the operands as signed values and code 001 multiplies them as unsigned values. The 64-bit product goes to HI (upper half) and LO (lower half) at the clock edge that accepts `start`. `done` is high for the following cycle and `busy` stays low.
- R2: Code 010 (signed) and code 011 (unsigned) add the 64-bit product to the current HI:LO value, wrapping modulo 2^64.
- R3: `rd_valid` is high together with `done` only for a multiply-family operation (codes 000 to 011) that was issued with `wb` high. For divides it stays low.
- R4: Code 100 divides signed and code 101 divides unsigned. The quotient goes to LO and the remainder to HI.
- R5: A signed quotient truncates toward zero: it is negated when the operand signs differ. The remainder carries the sign of the dividend.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0 without an exception.
- R7: A divide by zero leaves HI and LO unchanged. `dz_err` and `done` rise together for one cycle, one cycle after acceptance.
- R8: A nonzero divide keeps `busy` high for 33 cycles after acceptance (one setup cycle and 32 steps). `done` then pulses for one cycle with `busy` low. HI and LO change only at completion.
- R9: `start` is ignored while `busy` is high.
- R10: Codes 110 and 111 are ignored: no `done`, no `busy`, and HI and LO are unchanged.
- R11: Reset clears HI, LO, `busy`, `done`, `dz_err` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue request |
| op | input | 3 | Operation code |
| a | input | W | First operand / dividend |
| b | input | W | Second operand / divisor |
| wb | input | 1 | Request LO as destination result |
| busy | output | 1 | Divider in progress |
| done | output | 1 | Operation completed (one cycle) |
| dz_err | output | 1 | Divide-by-zero exception (one cycle) |
| rd_valid | output | 1 | LO is to be written to destination |
| hi | output | W | HI register |
| lo | output | W | LO register |

## Verification
The bench builds the unit at its default width of 32. At that width the 33-cycle divide timing and the most-negative-by-minus-one case can be exercised exactly. The operand extremes (all ones, sign bit alone) can also be reached, and they expose carry and sign errors in the 64-bit accumulation and the magnitude handling.

// File: rtl/muldiv_acc.sv
module muldiv_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wb,
  output logic         busy,
  output logic         done,
  output logic         dz_err,
  output logic         rd_valid,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W) + 1;

  typedef enum logic [1:0] {IDLE, SETUP, RUN} st_t;
  st_t st;

  logic [W-1:0] hi_r, lo_r, rem, quo, dvs;
  logic [CW-1:0] cnt;
  logic neg_q, neg_r, done_r, dz_r, rv_r;

  wire accept = start && (st == IDLE) && !(op[2] && op[1]);
  wire sgn    = ~op[0];

  wire [2*W-1:0] ext_a = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
  wire [2*W-1:0] ext_b = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
  wire [2*W-1:0] prod  = ext_a * ext_b;
  wire [2*W-1:0] acc   = op[1] ? ({hi_r, lo_r} + prod) : prod;

  wire a_neg = sgn && a[W-1];
  wire b_neg = sgn && b[W-1];
  wire [W-1:0] a_mag = a_neg ? -a : a;
  wire [W-1:0] b_mag = b_neg ? -b : b;

  wire [W:0]   shifted = {rem, quo[W-1]};
  wire [W:0]   diff    = shifted - {1'b0, dvs};
  wire         ge      = !diff[W];
  wire [W-1:0] nrem    = ge ? diff[W-1:0] : shifted[W-1:0];
  wire [W-1:0] nquo    = {quo[W-2:0], ge};
  wire [W-1:0] q_out   = neg_q ? -nquo : nquo;
  wire [W-1:0] r_out   = neg_r ? -nrem : nrem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      hi_r   <= '0;
      lo_r   <= '0;
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      done_r <= 1'b0;
      dz_r   <= 1'b0;
      rv_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      dz_r   <= 1'b0;
      rv_r   <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          if (!op[2]) begin
            {hi_r, lo_r} <= acc;
            done_r       <= 1'b1;
            rv_r         <= wb;
          end else begin
            quo   <= a_mag;
            dvs   <= b_mag;
            neg_q <= a_neg ^ b_neg;
            neg_r <= a_neg;
            st    <= SETUP;
          end
        end
        SETUP: begin
          if (dvs == '0) begin
            done_r <= 1'b1;
            dz_r   <= 1'b1;
            st     <= IDLE;
          end else begin
            rem <= '0;
            cnt <= '0;
            st  <= RUN;
          end
        end
        RUN: begin
          rem <= nrem;
          quo <= nquo;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) begin
            hi_r   <= r_out;
            lo_r   <= q_out;
            done_r <= 1'b1;
            st     <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy     = (st != IDLE);
  assign done     = done_r;
  assign dz_err   = dz_r;
  assign rd_valid = rv_r;
  assign hi       = hi_r;
  assign lo       = lo_r;
endmodule

// File: rtl/muldiv_acc_chk.sv
module muldiv_acc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op,
  input logic         busy,
  input logic         done,
  input logic         dz_err,
  input logic         rd_valid,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));

  // R7
  dz_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dz_err |-> done);

  // R7
  dz_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dz_err |-> ($stable(hi) && $stable(lo)));

  // R3
  rv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  // R1
  mul_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[2]) |=> (done && !busy));

  // R4
  div_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op[2] && !op[1]) |=> (busy && !done));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op[2] && op[1]) |=> (!done && !busy && $stable(hi) && $stable(lo)));
endmodule

bind muldiv_acc muldiv_acc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy),
  .done(done), .dz_err(dz_err), .rd_valid(rd_valid), .hi(hi), .lo(lo)
);

// File: tb/muldiv_acc_bench.sv
module muldiv_acc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        wb = 1'b0;
  logic        busy, done, dz_err, rd_valid;
  logic [31:0] hi, lo;

  int checks = 0, errors = 0;
  string cur_req = "R11";
  bit started = 0, finished = 0;

  muldiv_acc u_muldiv_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b), .wb(wb),
    .busy(busy), .done(done), .dz_err(dz_err), .rd_valid(rd_valid), .hi(hi), .lo(lo)
  );

  always #5 clk = ~clk;

  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  logic        m_done, m_dz, m_rv, p_zero;
  int          m_cnt;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_done = 0; m_dz = 0; m_rv = 0; m_cnt = 0;
    end else begin
      m_done = 0; m_dz = 0; m_rv = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          if (p_zero) m_dz = 1;
          else begin m_hi = p_hi; m_lo = p_lo; end
        end
      end else if (start && op <= 3'd5) begin
        if (op <= 3'd3) begin
          longint x, y;
          logic [63:0] pr, s;
          if (op[0]) begin x = longint'({32'b0, a}); y = longint'({32'b0, b}); end
          else begin x = longint'($signed(a)); y = longint'($signed(b)); end
          pr = x * y;
          s  = op[1] ? ({m_hi, m_lo} + pr) : pr;
          m_hi = s[63:32]; m_lo = s[31:0];
          m_done = 1; m_rv = wb;
        end else begin
          longint x, y, q, r;
          if (op[0]) begin x = longint'({32'b0, a}); y = longint'({32'b0, b}); end
          else begin x = longint'($signed(a)); y = longint'($signed(b)); end
          p_zero = (b == 0);
          if (!p_zero) begin
            q = x / y; r = x % y;
            p_lo = q[31:0]; p_hi = r[31:0];
          end
          m_cnt = p_zero ? 1 : 33;
        end
      end
    end
  end

  task automatic cmp(string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, name, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    cmp("hi", hi, m_hi);
    cmp("lo", lo, m_lo);
    cmp("busy", {31'b0, busy}, {31'b0, m_cnt > 0});
    cmp("done", {31'b0, done}, {31'b0, m_done});
    cmp("dz_err", {31'b0, dz_err}, {31'b0, m_dz});
    cmp("rd_valid", {31'b0, rd_valid}, {31'b0, m_rv});
  end

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic w, input string req);
    @(negedge clk);
    cur_req = req; op = o; a = x; b = y; wb = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    issue(3'd0, 32'hFFFF_FFFD, 32'd7, 0, "R1");
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R1");
    issue(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0, "R1");
    // R2
    issue(3'd2, 32'h1234_5678, 32'hFFFF_FF00, 0, "R2");
    issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2");
    issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2");
    // R3
    issue(3'd0, 32'd6, 32'd9, 1, "R3");
    issue(3'd2, 32'd3, 32'd5, 1, "R3");
    issue(3'd5, 32'd50, 32'd7, 1, "R3");
    // R1 back to back multiplies
    @(negedge clk);
    cur_req = "R1"; op = 3'd1; a = 32'd11; b = 32'd13; wb = 1'b1; start = 1'b1;
    @(negedge clk);
    op = 3'd2; a = 32'hFFFF_FFFF; b = 32'd2; wb = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    // R4
    issue(3'd5, 32'd100, 32'd7, 0, "R4");
    issue(3'd5, 32'hFFFF_FFFF, 32'd1, 0, "R4");
    issue(3'd5, 32'd5, 32'd9, 0, "R4");
    issue(3'd4, 32'd1000, 32'd33, 0, "R4");
    // R5
    issue(3'd4, 32'hFFFF_FFF9, 32'd2, 0, "R5");
    issue(3'd4, 32'd7, 32'hFFFF_FFFE, 0, "R5");
    issue(3'd4, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R5");
    issue(3'd5, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R5");
    // R6
    issue(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R6");
    // R7
    issue(3'd4, 32'd5, 32'd0, 0, "R7");
    issue(3'd5, 32'd0, 32'd0, 1, "R7");
    // R8 and R9: start pulsed while divider busy
    @(negedge clk);
    cur_req = "R9"; op = 3'd5; a = 32'd77; b = 32'd5; wb = 1'b0; start = 1'b1;
    @(negedge clk);
    op = 3'd0; a = 32'd2; b = 32'd3; wb = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    cur_req = "R8";
    while (busy) @(negedge clk);
    @(negedge clk);
    // R10
    issue(3'd6, 32'd4, 32'd4, 1, "R10");
    issue(3'd7, 32'd4, 32'd0, 1, "R10");
    // R11
    @(negedge clk);
    cur_req = "R11"; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    checks++; errors++;
    $display("FAIL watchdog %s actual=hung expected=complete", cur_req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule